// File: doc/BRIEF.md
# Duplex Replica Arbiter with Reconfiguration Control

This block sits behind two identical copies of a combinational function. Both copies see the same primary input. Each returns a data word and a two-rail health code from its own self-checking logic. On every valid input cycle the block does two things at once. It compares the two words, and it decodes both health codes. From these it decides whether to forward a result, which replica to take it from, or whether to withhold it and flag an unresolved disagreement. The decision appears one registered cycle after the input.

A replica whose health code reports a fault is taken out of service. A reconfiguration request for that replica goes to an external processor, and the request stays high until the processor acknowledges it. The block then waits for the processor's completion pulse. After that it needs one clean compared cycle before the replica rejoins. While one replica is out, the block runs on the other alone, trusting its health code. If that replica then fails, there is nothing left to compare against. A sticky system failure is raised and output valid stays low until reset. A saturating fault counter per replica is presented for the processor to read.

Top module: `duplex_guard`

## Requirements
- R1: After reset, out_valid, unresolved and sys_fail are low, both cfg_req bits are low, both replicas are in service and both fault counters read 0.
- R2: A health code of 2'b10 means healthy. The codes 2'b01, 2'b00 and 2'b11 all mean faulty for that replica.
- R3: The result of an input cycle appears one clock later. When in_valid is low, out_valid is low in the following cycle.
- R4: With both replicas in service, equal words and both healthy, word A is forwarded. If exactly one replica is faulty, the healthy replica's word is forwarded and the faulty replica is sent for reconfiguration, whether or not the words agree.
- R5: With both replicas in service, the output is withheld and unresolved pulses high for one cycle in two cases: both replicas are faulty, or both are healthy with different words. Neither replica is sent for reconfiguration.
- R6: A replica's cfg_req (bit 0 = A, bit 1 = B) rises in the cycle after the replica is judged faulty and stays high until its cfg_ack is sampled. The replica then waits for cfg_done. A cfg_ack or cfg_done for a replica that is not at that step has no effect.
- R7: After cfg_done, a replica rejoins service only on a valid cycle where its word equals the in-service word and both codes are healthy. A valid cycle that fails this sends it back to requesting reconfiguration.
- R8: While one replica is out of service, the in-service replica's word is forwarded whenever its code is healthy. The other replica's word and code do not affect the output and do not change its fault counter.
- R9: If the only in-service replica reports a fault, sys_fail rises and stays high until reset. While it is high, out_valid and both cfg_req bits are low.
- R10: Each replica's fault counter adds one on every valid cycle where that replica is in service or rejoining and its code is faulty. The counter holds at its maximum value, 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Replica outputs are valid this cycle |
| a_word | input | W | Data word from replica A |
| a_chk | input | 2 | Two-rail health code from replica A |
| b_word | input | W | Data word from replica B |
| b_chk | input | 2 | Two-rail health code from replica B |
| out_valid | output | 1 | Forwarded word is valid |
| out_word | output | W | Forwarded word |
| unresolved | output | 1 | Disagreement that cannot be attributed, output withheld |
| sys_fail | output | 1 | Sticky failure: no trusted replica remains |
| cfg_req | output | 2 | Reconfiguration request per replica (bit 0 = A) |
| cfg_ack | input | 2 | Processor accepted the request |
| cfg_done | input | 2 | Processor finished reconfiguring |
| a_errs | output | CNT_W | Saturating fault count of replica A |
| b_errs | output | CNT_W | Saturating fault count of replica B |

## Verification
The hardest state to reach from the ports is a replica in its rejoin step while the in-service replica fails or the words differ. Getting there takes a specific chain: a fault, an acknowledge, a completion pulse, and then a chosen next valid cycle. Directed sequences walk that chain for both outcomes of the rejoin cycle. A long random run with fixed-seed $urandom does the rest. It injects invalid codes and word differences, and fires acknowledge and completion pulses at random, including at replicas not waiting for them. Whenever the system fails it resets and starts again.

// File: rtl/dg_pkg.sv
`timescale 1ns/100ps
package dg_pkg;
    typedef enum logic [1:0] {
        RS_ACTIVE = 2'd0,
        RS_REQ    = 2'd1,
        RS_BUSY   = 2'd2,
        RS_RESYNC = 2'd3
    } rep_state_e;

    localparam logic [1:0] CHK_HEALTHY = 2'b10;

    function automatic logic chk_healthy(input logic [1:0] code);
        return code == CHK_HEALTHY;
    endfunction
endpackage

// File: rtl/dg_arbiter.sv
`timescale 1ns/100ps
module dg_arbiter
    import dg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          in_valid,
    input  logic          halt,
    input  logic [W-1:0]  word_a,
    input  logic [W-1:0]  word_b,
    input  logic [1:0]    healthy,
    input  rep_state_e    st_a,
    input  rep_state_e    st_b,
    output logic          fwd_valid,
    output logic [W-1:0]  fwd_word,
    output logic          unres,
    output logic [1:0]    fault,
    output logic [1:0]    rejoin,
    output logic          fatal
);
    logic [1:0] act;
    logic [1:0] rsy;
    logic       same;

    always_comb begin
        act  = {st_b == RS_ACTIVE, st_a == RS_ACTIVE};
        rsy  = {st_b == RS_RESYNC, st_a == RS_RESYNC};
        same = (word_a == word_b);
        fwd_valid = 1'b0;
        fwd_word  = word_a;
        unres     = 1'b0;
        fault     = 2'b00;
        rejoin    = 2'b00;
        fatal     = 1'b0;
        if (in_valid && !halt) begin
            if (act == 2'b11) begin
                unique case (healthy)
                    2'b11: begin
                        if (same) fwd_valid = 1'b1;
                        else      unres     = 1'b1;
                    end
                    2'b01: begin
                        fwd_valid = 1'b1;
                        fault[1]  = 1'b1;
                    end
                    2'b10: begin
                        fwd_valid = 1'b1;
                        fwd_word  = word_b;
                        fault[0]  = 1'b1;
                    end
                    default: unres = 1'b1;
                endcase
            end else if (act[0]) begin
                if (healthy[0]) begin
                    fwd_valid = 1'b1;
                    if (rsy[1]) begin
                        if (healthy[1] && same) rejoin[1] = 1'b1;
                        else                    fault[1]  = 1'b1;
                    end
                end else begin
                    fatal = 1'b1;
                end
            end else if (act[1]) begin
                fwd_word = word_b;
                if (healthy[1]) begin
                    fwd_valid = 1'b1;
                    if (rsy[0]) begin
                        if (healthy[0] && same) rejoin[0] = 1'b1;
                        else                    fault[0]  = 1'b1;
                    end
                end else begin
                    fatal = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dg_replica_fsm.sv
`timescale 1ns/100ps
module dg_replica_fsm
    import dg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt,
    input  logic       fault,
    input  logic       rejoin,
    input  logic       ack,
    input  logic       done,
    output rep_state_e state,
    output logic       req
);
    typedef struct packed {
        rep_state_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!halt) begin
            unique case (fsm_q.st)
                RS_ACTIVE: if (fault) fsm_d.st = RS_REQ;
                RS_REQ:    if (ack)   fsm_d.st = RS_BUSY;
                RS_BUSY:   if (done)  fsm_d.st = RS_RESYNC;
                RS_RESYNC: begin
                    if (rejoin)     fsm_d.st = RS_ACTIVE;
                    else if (fault) fsm_d.st = RS_REQ;
                end
                default: fsm_d.st = RS_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: RS_ACTIVE};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;
    assign req   = (fsm_q.st == RS_REQ) && !halt;
endmodule

// File: rtl/dg_err_counter.sv
`timescale 1ns/100ps
module dg_err_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/duplex_guard.sv
`timescale 1ns/100ps
module duplex_guard
    import dg_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     a_word,
    input  logic [1:0]       a_chk,
    input  logic [W-1:0]     b_word,
    input  logic [1:0]       b_chk,
    output logic             out_valid,
    output logic [W-1:0]     out_word,
    output logic             unresolved,
    output logic             sys_fail,
    output logic [1:0]       cfg_req,
    input  logic [1:0]       cfg_ack,
    input  logic [1:0]       cfg_done,
    output logic [CNT_W-1:0] a_errs,
    output logic [CNT_W-1:0] b_errs
);
    localparam int NREP = 2;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] word;
        logic         unres;
        logic         sfail;
    } out_s;

    out_s out_d, out_q;

    logic [1:0]      healthy;
    rep_state_e      st [NREP];
    logic [1:0]      fault, rejoin;
    logic            fwd_valid, unres_c, fatal;
    logic [W-1:0]    fwd_word;
    logic [CNT_W-1:0] errs [NREP];

    assign healthy = {chk_healthy(b_chk), chk_healthy(a_chk)};

    dg_arbiter #(.W(W)) u_arb (
        .in_valid (in_valid),
        .halt     (out_q.sfail),
        .word_a   (a_word),
        .word_b   (b_word),
        .healthy  (healthy),
        .st_a     (st[0]),
        .st_b     (st[1]),
        .fwd_valid(fwd_valid),
        .fwd_word (fwd_word),
        .unres    (unres_c),
        .fault    (fault),
        .rejoin   (rejoin),
        .fatal    (fatal)
    );

    for (genvar i = 0; i < NREP; i++) begin : g_rep
        logic counted;
        assign counted = in_valid && !out_q.sfail && !healthy[i]
                       && (st[i] == RS_ACTIVE || st[i] == RS_RESYNC);

        dg_replica_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .halt  (out_q.sfail),
            .fault (fault[i]),
            .rejoin(rejoin[i]),
            .ack   (cfg_ack[i]),
            .done  (cfg_done[i]),
            .state (st[i]),
            .req   (cfg_req[i])
        );

        dg_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (counted),
            .count(errs[i])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.vld   = fwd_valid;
        out_d.unres = unres_c;
        out_d.sfail = out_q.sfail | fatal;
        if (fwd_valid) out_d.word = fwd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_word   = out_q.word;
    assign unresolved = out_q.unres;
    assign sys_fail   = out_q.sfail;
    assign a_errs     = errs[0];
    assign b_errs     = errs[1];
endmodule

// File: rtl/dg_guard_checker.sv
`timescale 1ns/100ps
module dg_guard_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             unresolved,
    input logic             sys_fail,
    input logic [1:0]       cfg_req,
    input logic [1:0]       cfg_ack,
    input logic [CNT_W-1:0] a_errs,
    input logic [CNT_W-1:0] b_errs
);
    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_single_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_req));

    assert_withheld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        unresolved |-> !out_valid);

    assert_req_held_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req[0] && !cfg_ack[0]) |=> (cfg_req[0] || sys_fail));

    assert_req_held_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req[1] && !cfg_ack[1]) |=> (cfg_req[1] || sys_fail));

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_fail |=> sys_fail);

    assert_fail_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_fail |-> (!out_valid && cfg_req == 2'b00));

    assert_cnt_a_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a_errs >= $past(a_errs)));

    assert_cnt_b_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (b_errs >= $past(b_errs)));
endmodule

bind duplex_guard dg_guard_checker #(.CNT_W(CNT_W)) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .unresolved(unresolved),
    .sys_fail  (sys_fail),
    .cfg_req   (cfg_req),
    .cfg_ack   (cfg_ack),
    .a_errs    (a_errs),
    .b_errs    (b_errs)
);

// File: tb/duplex_guard_test.sv
`timescale 1ns/100ps
module duplex_guard_test;
    localparam int W     = 16;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [W-1:0]     a_word = '0, b_word = '0;
    logic [1:0]       a_chk = 2'b10, b_chk = 2'b10;
    logic             out_valid, unresolved, sys_fail;
    logic [W-1:0]     out_word;
    logic [1:0]       cfg_req;
    logic [1:0]       cfg_ack = 2'b00, cfg_done = 2'b00;
    logic [CNT_W-1:0] a_errs, b_errs;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model: 0 in service, 1 requesting, 2 reconfiguring, 3 rejoining
    int           m_st [2];
    bit           m_fail;
    int           m_cnt [2];
    bit           e_vld, e_unres;
    logic [W-1:0] e_word;

    always #2.5 clk = ~clk;

    duplex_guard #(.W(W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_word(a_word), .a_chk(a_chk), .b_word(b_word), .b_chk(b_chk),
        .out_valid(out_valid), .out_word(out_word), .unresolved(unresolved),
        .sys_fail(sys_fail), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
        .cfg_done(cfg_done), .a_errs(a_errs), .b_errs(b_errs)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic bit good(input logic [1:0] c);
        return c == 2'b10;   // R2
    endfunction

    task automatic model_step();
        bit ok [2];
        bit same, fatal;
        bit flt [2], rj [2];
        ok[0] = good(a_chk); ok[1] = good(b_chk);
        same = (a_word == b_word);
        fatal = 0; flt[0] = 0; flt[1] = 0; rj[0] = 0; rj[1] = 0;
        e_vld = 0; e_unres = 0;
        if (in_valid && !m_fail) begin
            if (m_st[0] == 0 && m_st[1] == 0) begin
                if (ok[0] && ok[1]) begin
                    if (same) begin e_vld = 1; e_word = a_word; end
                    else e_unres = 1;
                end else if (ok[0]) begin e_vld = 1; e_word = a_word; flt[1] = 1; end
                else if (ok[1]) begin e_vld = 1; e_word = b_word; flt[0] = 1; end
                else e_unres = 1;
            end else begin
                for (int s = 0; s < 2; s++) begin
                    if (m_st[s] == 0) begin
                        if (ok[s]) begin
                            e_vld = 1; e_word = (s == 0) ? a_word : b_word;
                            if (m_st[1-s] == 3) begin
                                if (ok[1-s] && same) rj[1-s] = 1; else flt[1-s] = 1;
                            end
                        end else fatal = 1;
                    end
                end
            end
            for (int i = 0; i < 2; i++)
                if ((m_st[i] == 0 || m_st[i] == 3) && !ok[i] && m_cnt[i] < CMAX) m_cnt[i]++;
        end
        if (!m_fail) begin
            for (int i = 0; i < 2; i++) begin
                case (m_st[i])
                    0: if (flt[i]) m_st[i] = 1;
                    1: if (cfg_ack[i]) m_st[i] = 2;
                    2: if (cfg_done[i]) m_st[i] = 3;
                    default: if (rj[i]) m_st[i] = 0; else if (flt[i]) m_st[i] = 1;
                endcase
            end
        end
        m_fail = m_fail | fatal;
    endtask

    task automatic compare_all();
        check("R3 out_valid", out_valid, e_vld);
        if (e_vld) check("R4 out_word", out_word, e_word);
        check("R5 unresolved", unresolved, e_unres);
        check("R9 sys_fail", sys_fail, m_fail);
        check("R6 cfg_req", cfg_req,
              {(m_st[1] == 1 && !m_fail), (m_st[0] == 1 && !m_fail)});
        check("R10 a_errs", a_errs, m_cnt[0]);
        check("R10 b_errs", b_errs, m_cnt[1]);
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit v, input logic [W-1:0] a, input logic [1:0] ac,
                         input logic [W-1:0] b, input logic [1:0] bc,
                         input logic [1:0] ack, input logic [1:0] dn);
        in_valid = v; a_word = a; a_chk = ac; b_word = b; b_chk = bc;
        cfg_ack = ack; cfg_done = dn;
        step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; cfg_ack = 0; cfg_done = 0;
        repeat (2) @(negedge clk);
        m_st[0] = 0; m_st[1] = 0; m_fail = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        e_vld = 0; e_unres = 0;
        rst_n = 1;
        check("R1 out_valid", out_valid, 0);
        check("R1 sys_fail", sys_fail, 0);
        check("R1 unresolved", unresolved, 0);
        check("R1 cfg_req", cfg_req, 0);
        check("R1 errs", {a_errs, b_errs}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R3: plain agreement, then an idle cycle
        drive(1, 16'h1234, 2'b10, 16'h1234, 2'b10, 0, 0);
        check("R3 forwarded A", out_word, 16'h1234);
        drive(0, 16'h1111, 2'b10, 16'h1111, 2'b10, 0, 0);
        check("R3 idle gives no valid", out_valid, 0);

        // R2: each invalid code on B marks it faulty
        for (int k = 0; k < 3; k++) begin
            logic [1:0] code;
            code = (k == 0) ? 2'b00 : (k == 1) ? 2'b11 : 2'b01;
            do_reset();
            drive(1, 16'hA5A5, 2'b10, 16'hA5A5, code, 0, 0);
            check("R2 invalid code flags B", cfg_req, 2'b10);
            check("R2 output still valid", out_valid, 1);
        end

        // R4: words differ, A faulty -> B forwarded, A requested
        do_reset();
        drive(1, 16'h0F0F, 2'b01, 16'h7777, 2'b10, 0, 0);
        check("R4 B forwarded", out_word, 16'h7777);
        check("R4 A requested", cfg_req, 2'b01);

        // R6: request held without ack, ignored done
        drive(1, 16'h2222, 2'b11, 16'h2222, 2'b10, 2'b10, 2'b01);
        check("R6 request held", cfg_req, 2'b01);
        drive(1, 16'h3333, 2'b10, 16'h3333, 2'b10, 2'b01, 0);
        check("R6 request dropped after ack", cfg_req, 2'b00);

        // R8: A out of service, garbage on A ignored
        drive(1, 16'hDEAD, 2'b00, 16'h4444, 2'b10, 0, 0);
        check("R8 in-service word forwarded", out_word, 16'h4444);
        check("R8 out-of-service count unchanged", a_errs, 1);

        // R7: done, then a dirty rejoin cycle sends A back
        drive(0, 0, 2'b10, 0, 2'b10, 0, 2'b01);
        drive(1, 16'h5555, 2'b10, 16'h5556, 2'b10, 0, 0);
        check("R7 failed rejoin re-requests", cfg_req, 2'b01);
        drive(0, 0, 2'b10, 0, 2'b10, 2'b01, 0);
        drive(0, 0, 2'b10, 0, 2'b10, 0, 2'b01);
        drive(1, 16'h6666, 2'b10, 16'h6666, 2'b10, 0, 0);
        // back in duplex: A faulty again must be requested
        drive(1, 16'h7070, 2'b01, 16'h7070, 2'b10, 0, 0);
        check("R7 rejoined then flagged", cfg_req, 2'b01);

        // R9: only in-service replica fails
        drive(1, 16'h8888, 2'b10, 16'h8888, 2'b00, 0, 0);
        check("R9 sys_fail set", sys_fail, 1);
        drive(1, 16'h9999, 2'b10, 16'h9999, 2'b10, 2'b01, 0);
        check("R9 sticky no valid", {sys_fail, out_valid, cfg_req}, 4'b1000);

        // R5 + R10: both faulty repeatedly, counters saturate
        do_reset();
        for (int k = 0; k < 20; k++)
            drive(1, 16'h1000 + k[15:0], 2'b11, 16'h2000, 2'b01, 0, 0);
        check("R5 withheld, no request", {unresolved, out_valid, cfg_req}, 4'b1000);
        check("R10 saturated", {a_errs, b_errs}, {4'hF, 4'hF});
        drive(1, 16'h1, 2'b10, 16'h2, 2'b10, 0, 0);
        check("R5 both healthy differ", unresolved, 1);

        // random phase
        do_reset();
        for (int n = 0; n < 6000; n++) begin
            logic [W-1:0] aw, bw;
            logic [1:0] ac, bc;
            aw = W'($urandom);
            bw = ($urandom % 8 == 0) ? W'($urandom) : aw;
            ac = ($urandom % 6 == 0) ? 2'($urandom) : 2'b10;
            bc = ($urandom % 6 == 0) ? 2'($urandom) : 2'b10;
            drive($urandom % 4 != 0, aw, ac, bw, bc,
                  2'($urandom & 32'h3 & {2{$urandom % 3 == 0}}),
                  2'($urandom & 32'h3 & {2{$urandom % 4 == 0}}));
            if ((m_fail && $urandom % 4 == 0) || n % 500 == 499) do_reset();
        end

        finish_run();
    end
endmodule